// File: doc/BRIEF.md
# I2C Write Target with Clock Stretching

This block is the receive side of an I2C target. It watches the two bus lines, finds Start, repeated Start and Stop conditions, and compares the first byte of each transfer with its own address. The address may be a 7-bit address, or a 10-bit address that arrives as a header byte followed by a second byte. The block acknowledges every matched address byte and every data byte it accepts. The bus master can only write to it.

Software runs the block through a small strobed register port and one event interrupt. Three event flags report progress: the address was matched, a byte is waiting, and a Stop was seen. The address flag and the stop flag each clear only through a two-step access sequence. The block holds SCL low while an event is still waiting for software. A matched address stops the bus until software finishes its sequence. A received byte stops the bus only when software has not read the previous byte by the time the next byte is complete.

Register map (3-bit index): 0 status A, 1 status B, 2 received data, 3 control, 4 own address low byte, 5 own address high byte. Status A has the address flag in bit 0, the byte flag in bit 1 and the stop flag in bit 2. Status B has bus busy in bit 0 and "addressed in this transfer" in bit 1. Control has the enable in bit 0 and the interrupt enable in bit 1. The own-address high register selects 10-bit mode with bit 7 and holds address bits 9:8 in bits 1:0.

Top module: `i2c_tgt_rx`

## Requirements
- R1: When the address matches and its ACK clock has ended, status A bit 0 is set. This flag clears only when status A (index 0) is read and status B (index 1) is read after that. A read of status B alone leaves the flag set.
- R2: While status A bit 0 is set after an address match, `scl_hold` stays 1. Once the clearing sequence completes, `scl_hold` returns to 0 within a few cycles.
- R3: Each accepted data byte sets status A bit 1. A read of index 2 returns the byte and clears bit 1.
- R4: If bit 1 is still set when the eighth bit of the next byte has been clocked in and SCL falls, `scl_hold` stays 1 until index 2 is read. After that read the new byte is acknowledged and no byte is lost.
- R5: A Stop that ends a transfer in which the address matched sets status A bit 2. The flag clears only when status A is read and control (index 3) is written after that. A control write alone leaves it set.
- R6: `evt_irq` equals control bit 1 AND the OR of status A bits 2:0.
- R7: In 10-bit mode (own-high bit 7 = 1), the header byte 11110, a9, a8, 0 is acknowledged and does not set the address flag. A second byte equal to the own-low register is acknowledged and then sets the address flag. Any other second byte is not acknowledged.
- R8: When the address flag and the stop flag are both set, one read of status A clears neither. Each flag then clears through its own sequence.
- R9: The target pulls SDA low during the ninth clock after each matched address byte and each accepted data byte. For a byte that does not match, it sends no ACK, sets no flag and does not stretch SCL, and a later Stop sets nothing.
- R10: In 7-bit mode the first byte matches only when its upper seven bits equal own-low bits 6:0 and its last bit is 0 (write). With control bit 0 clear, the block ignores the bus.
- R11: A repeated Start restarts the address phase, and a matching address sets the address flag again.
- R12: After reset all flags read 0, `evt_irq` is 0, and `scl_hold` and `sda_pull` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Sensed SCL line level |
| sda_in | input | 1 | Sensed SDA line level |
| scl_hold | output | 1 | 1 pulls SCL low (stretch) |
| sda_pull | output | 1 | 1 pulls SDA low (ACK) |
| reg_sel | input | 3 | Register index |
| reg_rd | input | 1 | One-cycle read strobe |
| reg_wr | input | 1 | One-cycle write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the selected index, combinational |
| evt_irq | output | 1 | Event interrupt |

## Verification
The bench targets the clear sequences when they are done wrong or out of order. It reads status B without a prior status A read, writes control without a prior status A read, and reads status A while both flags are set. A design that clears on any single access would drop an event. A design that clears both flags on one status A read would release the bus while software still believes a Stop is pending. The bench also withholds the data read across a whole byte. A design that does not stretch there would overwrite the unread byte, and the queue check would catch it. A 10-bit header on its own must produce no address event. Mismatched and read-direction addresses must leave the bus untouched, and any stray ACK or stretch there would be seen on the lines.

// File: rtl/i2c_tgt_pkg.sv
`timescale 1ns/1ps
package i2c_tgt_pkg;

    localparam int REG_AW   = 3;
    localparam int BYTE_W   = 8;
    localparam int BITCNT_W = $clog2(BYTE_W + 1);

    typedef logic [REG_AW-1:0] reg_idx_t;

    localparam reg_idx_t RIX_STAT_A = 3'd0;
    localparam reg_idx_t RIX_STAT_B = 3'd1;
    localparam reg_idx_t RIX_DATA   = 3'd2;
    localparam reg_idx_t RIX_CTRL   = 3'd3;
    localparam reg_idx_t RIX_OWN_LO = 3'd4;
    localparam reg_idx_t RIX_OWN_HI = 3'd5;

    // status A bit positions
    localparam int FLG_ADDR = 0;
    localparam int FLG_RX   = 1;
    localparam int FLG_STOP = 2;
    // control bit positions
    localparam int CTL_EN   = 0;
    localparam int CTL_IE   = 1;
    // own-address high register
    localparam int OWN_TEN  = 7;

    // fixed prefix of a 10-bit header byte
    localparam logic [4:0] HDR_TAG = 5'b11110;

    typedef enum logic [3:0] {
        LS_IDLE,
        LS_ADDR1,
        LS_ACK_HDR,
        LS_ADDR2,
        LS_ACK_ADR,
        LS_HOLD,
        LS_DATA,
        LS_WAIT_RD,
        LS_ACK_DAT,
        LS_SKIP
    } link_st_e;

endpackage

// File: rtl/i2c_tgt_sync.sv
`timescale 1ns/1ps
module i2c_tgt_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    typedef struct packed {
        logic [STAGES-1:0] scl_pipe;
        logic [STAGES-1:0] sda_pipe;
        logic              scl_last;
        logic              sda_last;
    } sy_t;

    sy_t q, d;

    always_comb begin
        d = q;
        d.scl_pipe[0] = scl_in;
        d.sda_pipe[0] = sda_in;
        for (int i = 1; i < STAGES; i++) begin
            d.scl_pipe[i] = q.scl_pipe[i-1];
            d.sda_pipe[i] = q.sda_pipe[i-1];
        end
        d.scl_last = q.scl_pipe[STAGES-1];
        d.sda_last = q.sda_pipe[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '1;
        else        q <= d;
    end

    assign scl_s     = q.scl_pipe[STAGES-1];
    assign sda_s     = q.sda_pipe[STAGES-1];
    assign scl_rise  = scl_s & ~q.scl_last;
    assign scl_fall  = ~scl_s & q.scl_last;
    assign start_det = scl_s & q.scl_last & q.sda_last & ~sda_s;
    assign stop_det  = scl_s & q.scl_last & ~q.sda_last & sda_s;

endmodule

// File: rtl/i2c_tgt_link.sv
`timescale 1ns/1ps
module i2c_tgt_link
    import i2c_tgt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              ten_bit,
    input  logic [9:0]        own_addr,
    input  logic              scl_s,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic              addr_pend,
    input  logic              rx_pend,
    output logic              sda_oe,
    output logic              scl_oe,
    output logic              addr_evt,
    output logic              rx_push,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              stop_evt,
    output logic              busy,
    output logic              addressed
);

    typedef struct packed {
        link_st_e            st;
        logic [BYTE_W-1:0]   shreg;
        logic [BITCNT_W-1:0] cnt;
        logic                sda_oe;
        logic                scl_oe;
        logic                addressed;
        logic                busy;
        logic                addr_evt;
        logic                rx_push;
        logic                stop_evt;
    } lk_t;

    lk_t  q, d;
    logic byte_done;
    logic shifting;
    logic hdr_hit;
    logic sev_hit;
    logic lo_hit;

    always_comb begin
        shifting  = (q.st == LS_ADDR1) || (q.st == LS_ADDR2) || (q.st == LS_DATA);
        byte_done = scl_fall && (q.cnt == BITCNT_W'(BYTE_W));
        hdr_hit   = ten_bit && (q.shreg[7:3] == HDR_TAG)
                    && (q.shreg[2:1] == own_addr[9:8]) && !q.shreg[0];
        sev_hit   = !ten_bit && (q.shreg[7:1] == own_addr[6:0]) && !q.shreg[0];
        lo_hit    = (q.shreg == own_addr[7:0]);

        d          = q;
        d.addr_evt = 1'b0;
        d.rx_push  = 1'b0;
        d.stop_evt = 1'b0;

        if (stop_det) begin
            d.st        = LS_IDLE;
            d.sda_oe    = 1'b0;
            d.scl_oe    = 1'b0;
            d.busy      = 1'b0;
            d.stop_evt  = q.addressed;
            d.addressed = 1'b0;
        end else if (start_det) begin
            d.busy   = 1'b1;
            d.sda_oe = 1'b0;
            d.scl_oe = 1'b0;
            d.cnt    = '0;
            d.st     = en ? LS_ADDR1 : LS_SKIP;
        end else begin
            if (shifting && scl_rise && (q.cnt < BITCNT_W'(BYTE_W))) begin
                d.shreg = {q.shreg[BYTE_W-2:0], sda_s};
                d.cnt   = q.cnt + 1'b1;
            end
            unique case (q.st)
                LS_ADDR1: begin
                    if (byte_done) begin
                        if (hdr_hit) begin
                            d.st     = LS_ACK_HDR;
                            d.sda_oe = 1'b1;
                        end else if (sev_hit) begin
                            d.st     = LS_ACK_ADR;
                            d.sda_oe = 1'b1;
                        end else begin
                            d.st = LS_SKIP;
                        end
                    end
                end
                LS_ACK_HDR: begin
                    if (scl_fall) begin
                        d.sda_oe = 1'b0;
                        d.cnt    = '0;
                        d.st     = LS_ADDR2;
                    end
                end
                LS_ADDR2: begin
                    if (byte_done) begin
                        if (lo_hit) begin
                            d.st     = LS_ACK_ADR;
                            d.sda_oe = 1'b1;
                        end else begin
                            d.st = LS_SKIP;
                        end
                    end
                end
                LS_ACK_ADR: begin
                    if (scl_fall) begin
                        d.sda_oe    = 1'b0;
                        d.addr_evt  = 1'b1;
                        d.addressed = 1'b1;
                        d.scl_oe    = 1'b1;
                        d.st        = LS_HOLD;
                    end
                end
                LS_HOLD: begin
                    if (!addr_pend && !q.addr_evt) begin
                        d.scl_oe = 1'b0;
                        d.cnt    = '0;
                        d.st     = LS_DATA;
                    end
                end
                LS_DATA: begin
                    if (byte_done) begin
                        if (rx_pend) begin
                            d.scl_oe = 1'b1;
                            d.st     = LS_WAIT_RD;
                        end else begin
                            d.rx_push = 1'b1;
                            d.sda_oe  = 1'b1;
                            d.st      = LS_ACK_DAT;
                        end
                    end
                end
                LS_WAIT_RD: begin
                    if (!rx_pend) begin
                        d.rx_push = 1'b1;
                        d.sda_oe  = 1'b1;
                        d.scl_oe  = 1'b0;
                        d.st      = LS_ACK_DAT;
                    end
                end
                LS_ACK_DAT: begin
                    if (scl_fall) begin
                        d.sda_oe = 1'b0;
                        d.cnt    = '0;
                        d.st     = LS_DATA;
                    end
                end
                default: begin
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign sda_oe    = q.sda_oe;
    assign scl_oe    = q.scl_oe;
    assign addr_evt  = q.addr_evt;
    assign rx_push   = q.rx_push;
    assign rx_byte   = q.shreg;
    assign stop_evt  = q.stop_evt;
    assign busy      = q.busy;
    assign addressed = q.addressed;

    AST_ACK_STARTS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_s) else $error("ack began with SCL high"); // R9
    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == LS_HOLD && addr_pend) |=> scl_oe) else $error("address wait released SCL"); // R2
    AST_NO_OVERWRITE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_push |-> !rx_pend) else $error("byte pushed over unread data"); // R4
    AST_RX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == LS_WAIT_RD && rx_pend) |=> scl_oe) else $error("read wait released SCL"); // R4

endmodule

// File: rtl/i2c_tgt_regs.sv
`timescale 1ns/1ps
module i2c_tgt_regs
    import i2c_tgt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  reg_idx_t          sel,
    input  logic              rd,
    input  logic              wr,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              addr_evt,
    input  logic              rx_push,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic              stop_evt,
    input  logic              busy,
    input  logic              addressed,
    output logic [BYTE_W-1:0] rdata,
    output logic              irq,
    output logic              en,
    output logic              ten_bit,
    output logic [9:0]        own_addr,
    output logic              addr_pend,
    output logic              rx_pend
);

    typedef struct packed {
        logic              addr_f;
        logic              rx_f;
        logic              stop_f;
        logic              addr_arm;
        logic              stop_arm;
        logic [BYTE_W-1:0] data;
        logic [BYTE_W-1:0] ctrl;
        logic [BYTE_W-1:0] own_lo;
        logic [BYTE_W-1:0] own_hi;
    } rg_t;

    rg_t  q, d;
    logic sa_rd, sb_rd, dat_rd, ctl_wr;

    always_comb begin
        sa_rd  = rd && (sel == RIX_STAT_A);
        sb_rd  = rd && (sel == RIX_STAT_B);
        dat_rd = rd && (sel == RIX_DATA);
        ctl_wr = wr && (sel == RIX_CTRL);

        d = q;

        // first step of a clear: remember status A was seen with the flag up
        if (sa_rd && q.addr_f) d.addr_arm = 1'b1;
        if (sa_rd && q.stop_f) d.stop_arm = 1'b1;

        // second step completes only when armed
        if (sb_rd && q.addr_arm) begin
            d.addr_f   = 1'b0;
            d.addr_arm = 1'b0;
        end
        if (ctl_wr && q.stop_arm) begin
            d.stop_f   = 1'b0;
            d.stop_arm = 1'b0;
        end
        if (dat_rd) d.rx_f = 1'b0;

        if (wr) begin
            unique case (sel)
                RIX_CTRL:   d.ctrl   = wdata;
                RIX_OWN_LO: d.own_lo = wdata;
                RIX_OWN_HI: d.own_hi = wdata;
                default: begin
                end
            endcase
        end

        // new events win over a clear in the same cycle
        if (addr_evt) begin
            d.addr_f   = 1'b1;
            d.addr_arm = 1'b0;
        end
        if (stop_evt) begin
            d.stop_f   = 1'b1;
            d.stop_arm = 1'b0;
        end
        if (rx_push) begin
            d.rx_f = 1'b1;
            d.data = rx_byte;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        unique case (sel)
            RIX_STAT_A: rdata = {5'b0, q.stop_f, q.rx_f, q.addr_f};
            RIX_STAT_B: rdata = {6'b0, addressed, busy};
            RIX_DATA:   rdata = q.data;
            RIX_CTRL:   rdata = q.ctrl;
            RIX_OWN_LO: rdata = q.own_lo;
            RIX_OWN_HI: rdata = q.own_hi;
            default:    rdata = '0;
        endcase
    end

    assign irq       = q.ctrl[CTL_IE] & (q.addr_f | q.rx_f | q.stop_f);
    assign en        = q.ctrl[CTL_EN];
    assign ten_bit   = q.own_hi[OWN_TEN];
    assign own_addr  = {q.own_hi[1:0], q.own_lo};
    assign addr_pend = q.addr_f;
    assign rx_pend   = q.rx_f;

    AST_ADDR_CLR_PATH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(q.addr_f) |-> $past(rd && sel == RIX_STAT_B)) else $error("address flag cleared off sequence"); // R1
    AST_RX_CLR_PATH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(q.rx_f) |-> $past(rd && sel == RIX_DATA)) else $error("byte flag cleared without data read"); // R3
    AST_STOP_CLR_PATH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(q.stop_f) |-> $past(wr && sel == RIX_CTRL)) else $error("stop flag cleared off sequence"); // R5
    AST_SA_KEEPS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && sel == RIX_STAT_A && q.addr_f && q.stop_f) |=> (q.addr_f && q.stop_f)) else $error("status A read cleared a flag"); // R8

endmodule

// File: rtl/i2c_tgt_rx.sv
`timescale 1ns/1ps
module i2c_tgt_rx
    import i2c_tgt_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              scl_hold,
    output logic              sda_pull,
    input  logic [REG_AW-1:0] reg_sel,
    input  logic              reg_rd,
    input  logic              reg_wr,
    input  logic [BYTE_W-1:0] reg_wdata,
    output logic [BYTE_W-1:0] reg_rdata,
    output logic              evt_irq
);

    logic              scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic              en, ten_bit, addr_pend, rx_pend;
    logic [9:0]        own_addr;
    logic              addr_evt, rx_push, stop_evt, busy, addressed;
    logic [BYTE_W-1:0] rx_byte;

    i2c_tgt_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_in    (scl_in),
        .sda_in    (sda_in),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2c_tgt_link u_link (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .ten_bit   (ten_bit),
        .own_addr  (own_addr),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .addr_pend (addr_pend),
        .rx_pend   (rx_pend),
        .sda_oe    (sda_pull),
        .scl_oe    (scl_hold),
        .addr_evt  (addr_evt),
        .rx_push   (rx_push),
        .rx_byte   (rx_byte),
        .stop_evt  (stop_evt),
        .busy      (busy),
        .addressed (addressed)
    );

    i2c_tgt_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel       (reg_sel),
        .rd        (reg_rd),
        .wr        (reg_wr),
        .wdata     (reg_wdata),
        .addr_evt  (addr_evt),
        .rx_push   (rx_push),
        .rx_byte   (rx_byte),
        .stop_evt  (stop_evt),
        .busy      (busy),
        .addressed (addressed),
        .rdata     (reg_rdata),
        .irq       (evt_irq),
        .en        (en),
        .ten_bit   (ten_bit),
        .own_addr  (own_addr),
        .addr_pend (addr_pend),
        .rx_pend   (rx_pend)
    );

endmodule

// File: tb/i2c_tgt_rx_tb.sv
`timescale 1ns/1ps
module i2c_tgt_rx_tb_top;

    localparam int Q = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       m_scl_low = 1'b0;
    logic       m_sda_low = 1'b0;
    logic [2:0] reg_sel = '0;
    logic       reg_rd = 1'b0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       scl_hold, sda_pull, evt_irq;
    wire        scl_line = !(m_scl_low || scl_hold);
    wire        sda_line = !(m_sda_low || sda_pull);

    int   n_run = 0;
    int   n_fail = 0;
    bit   model_ie = 1'b0;
    bit   done = 1'b0;
    logic [7:0] exp_q[$];

    always #10 clk = ~clk;

    i2c_tgt_rx dut_i (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_line), .sda_in(sda_line),
        .scl_hold(scl_hold), .sda_pull(sda_pull), .reg_sel(reg_sel),
        .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .evt_irq(evt_irq)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    // every clock: interrupt against the model's enable and visible flags (R6)
    always @(posedge clk) begin
        #5;
        if (rst_n && reg_sel == 3'd0)
            chk("R6 irq per clock", int'(evt_irq), int'(model_ie && (reg_rdata[2:0] != 3'b0)));
    end

    task automatic qwait(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic scl_up();
        m_scl_low = 1'b0;
        @(negedge clk);
        while (!scl_line) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda_low = 1'b0; qwait(Q);
        scl_up();         qwait(Q);
        m_sda_low = 1'b1; qwait(2*Q);
        m_scl_low = 1'b1; qwait(Q);
    endtask

    task automatic bus_stop();
        m_sda_low = 1'b1; qwait(Q);
        scl_up();         qwait(Q);
        m_sda_low = 1'b0; qwait(2*Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output bit ack);
        for (int i = 7; i >= 0; i--) begin
            m_sda_low = !b[i]; qwait(Q);
            scl_up();          qwait(2*Q);
            m_scl_low = 1'b1;  qwait(Q);
        end
        m_sda_low = 1'b0; qwait(Q);
        scl_up();         qwait(Q);
        ack = !sda_line;  qwait(Q);
        m_scl_low = 1'b1; qwait(Q);
    endtask

    task automatic peek(input logic [2:0] s, output logic [7:0] v);
        @(negedge clk);
        reg_sel = s;
        #1 v = reg_rdata;
        reg_sel = 3'd0;
    endtask

    task automatic sw_read(input logic [2:0] s, output logic [7:0] v);
        @(negedge clk);
        reg_sel = s; reg_rd = 1'b1;
        #1 v = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0; reg_sel = 3'd0;
    endtask

    task automatic sw_write(input logic [2:0] s, input logic [7:0] v);
        @(negedge clk);
        reg_sel = s; reg_wr = 1'b1; reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0; reg_sel = 3'd0;
        if (s == 3'd3) model_ie = v[1];
    endtask

    task automatic read_data(input string req);
        logic [7:0] v;
        logic [7:0] e;
        sw_read(3'd2, v);
        e = (exp_q.size() > 0) ? exp_q.pop_front() : 8'hxx;
        chk(req, int'(v), int'(e));
    endtask

    task automatic clr_addr();
        logic [7:0] v;
        sw_read(3'd0, v);
        sw_read(3'd1, v);
    endtask

    task automatic clr_stop();
        logic [7:0] v;
        sw_read(3'd0, v);
        sw_write(3'd3, {6'b0, model_ie, 1'b1});
    endtask

    task automatic put_data(input logic [7:0] b, input string req);
        bit a;
        send_byte(b, a);
        exp_q.push_back(b);
        chk(req, int'(a), 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog act=running exp=finished");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] v;
        bit         a;
        bit         a2;

        qwait(3);
        rst_n = 1'b1;
        qwait(2);
        peek(3'd0, v);
        chk("R12 reset flags", int'(v), 0);
        chk("R12 reset irq", int'(evt_irq), 0);
        chk("R12 reset hold", int'(scl_hold), 0);
        chk("R12 reset pull", int'(sda_pull), 0);

        // 7-bit address 0x2A, enable + interrupt
        sw_write(3'd4, 8'h2A);
        sw_write(3'd5, 8'h00);
        sw_write(3'd3, 8'h03);

        bus_start();
        send_byte(8'h54, a);
        chk("R9 R10 address ack", int'(a), 1);
        qwait(4);
        peek(3'd0, v);
        chk("R1 addr flag set", int'(v), 1);
        chk("R2 stretch on address", int'(scl_hold), 1);
        chk("R6 irq on address", int'(evt_irq), 1);
        sw_read(3'd1, v);
        qwait(4);
        peek(3'd0, v);
        chk("R1 status B alone keeps flag", int'(v[0]), 1);
        sw_read(3'd0, v);
        qwait(4);
        peek(3'd0, v);
        chk("R1 status A alone keeps flag", int'(v[0]), 1);
        chk("R2 still stretched", int'(scl_hold), 1);
        sw_read(3'd1, v);
        qwait(4);
        peek(3'd0, v);
        chk("R1 sequence clears flag", int'(v[0]), 0);
        chk("R2 stretch released", int'(scl_hold), 0);

        put_data(8'hC3, "R9 data ack");
        peek(3'd0, v);
        chk("R3 byte flag set", int'(v), 2);
        read_data("R3 data value");
        peek(3'd0, v);
        chk("R3 byte flag cleared", int'(v), 0);

        // unread byte followed by another: stretch until read
        put_data(8'h11, "R9 data ack 2");
        done = 1'b0;
        fork
            begin
                send_byte(8'h22, a2);
                done = 1'b1;
            end
        join_none
        qwait(500);
        chk("R4 stretch while unread", int'(scl_hold), 1);
        chk("R4 master blocked", int'(done), 0);
        exp_q.push_back(8'h22);
        read_data("R4 first byte kept");
        wait (done);
        chk("R4 second byte acked", int'(a2), 1);
        read_data("R4 second byte kept");

        // stop sets flag; control write alone keeps it
        bus_stop();
        qwait(4);
        peek(3'd0, v);
        chk("R5 stop flag set", int'(v), 4);
        sw_write(3'd3, 8'h03);
        qwait(2);
        peek(3'd0, v);
        chk("R5 control write alone keeps flag", int'(v), 4);

        // both flags up together
        bus_start();
        send_byte(8'h54, a);
        qwait(4);
        peek(3'd0, v);
        chk("R8 both flags set", int'(v), 5);
        sw_read(3'd0, v);
        qwait(2);
        peek(3'd0, v);
        chk("R8 status A read clears neither", int'(v), 5);
        sw_read(3'd1, v);
        qwait(4);
        peek(3'd0, v);
        chk("R8 address cleared, stop kept", int'(v), 4);
        sw_write(3'd3, 8'h03);
        qwait(2);
        peek(3'd0, v);
        chk("R5 R8 stop cleared by sequence", int'(v), 0);

        // repeated start
        put_data(8'h5E, "R9 data ack 3");
        read_data("R3 data before restart");
        bus_start();
        send_byte(8'h54, a);
        chk("R11 restart address ack", int'(a), 1);
        qwait(4);
        peek(3'd0, v);
        chk("R11 address flag again", int'(v), 1);
        clr_addr();
        bus_stop();
        qwait(4);
        clr_stop();

        // mismatch and read direction
        bus_start();
        send_byte(8'h56, a);
        chk("R9 mismatch no ack", int'(a), 0);
        chk("R9 mismatch no stretch", int'(scl_hold), 0);
        bus_stop();
        qwait(4);
        peek(3'd0, v);
        chk("R9 mismatch no flags", int'(v), 0);
        bus_start();
        send_byte(8'h55, a);
        chk("R10 read bit not acked", int'(a), 0);
        bus_stop();
        qwait(4);
        peek(3'd0, v);
        chk("R10 read bit no flags", int'(v), 0);

        // interrupt disabled
        sw_write(3'd3, 8'h01);
        bus_start();
        send_byte(8'h54, a);
        qwait(4);
        peek(3'd0, v);
        chk("R6 flag set while masked", int'(v), 1);
        chk("R6 irq masked", int'(evt_irq), 0);
        clr_addr();
        bus_stop();
        qwait(4);
        clr_stop();
        sw_write(3'd3, 8'h03);

        // 10-bit address 0x2B5
        sw_write(3'd5, 8'h82);
        sw_write(3'd4, 8'hB5);
        bus_start();
        send_byte(8'hF4, a);
        chk("R7 header ack", int'(a), 1);
        qwait(2);
        peek(3'd0, v);
        chk("R7 header alone no flag", int'(v), 0);
        chk("R7 header no stretch", int'(scl_hold), 0);
        send_byte(8'hB5, a);
        chk("R7 second byte ack", int'(a), 1);
        qwait(4);
        peek(3'd0, v);
        chk("R7 flag after second byte", int'(v), 1);
        clr_addr();
        put_data(8'h7E, "R9 10-bit data ack");
        read_data("R7 10-bit data value");
        bus_stop();
        qwait(4);
        clr_stop();
        bus_start();
        send_byte(8'hF4, a);
        send_byte(8'hB6, a);
        chk("R7 wrong second byte no ack", int'(a), 0);
        bus_stop();
        qwait(4);
        peek(3'd0, v);
        chk("R7 wrong second byte no flags", int'(v), 0);

        // disabled block ignores the bus
        sw_write(3'd3, 8'h02);
        bus_start();
        send_byte(8'hF4, a);
        chk("R10 disabled no ack", int'(a), 0);
        bus_stop();
        qwait(4);
        peek(3'd0, v);
        chk("R10 disabled no flags", int'(v), 0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule